// File: doc/BRIEF.md
# Horizontal Sync Source Selector

This block watches two candidate horizontal sync inputs: a dedicated sync pin and a sliced sync-on-green signal. It reports whether each one is alive and picks which of them feeds the downstream PLL. An input counts as alive only while it keeps toggling. Holding it at a steady high or low level, for any length of time, makes it read as dead once a programmable window of clock cycles has passed without an edge.

The choice of source follows a small truth table. If exactly one input is alive, that input is chosen. If both inputs are alive, or neither is, a priority bit decides. An override bit makes the priority bit decide in every case.

The block also finds the polarity of the dedicated input by comparing how long it stays high with how long it stays low. The chosen sync signal is driven out after two-flop synchronization. When the dedicated pin is chosen, its pulses are flipped to active-high using the detected polarity.

Top module: `hsync_source_select`

## Requirements
- R1: `hs_active_o` is 1 while `hsync_i` toggles with no gap between edges longer than ACT_WINDOW clocks. It falls to 0 no more than ACT_WINDOW+3 clocks after `hsync_i` stops changing, whether it is held high or low.
- R2: `sog_active_o` follows the same rule for `sog_i`.
- R3: With `force_i`=0, `use_sog_o` is 0 when only the dedicated input is active and 1 when only the sync-on-green input is active (0 = dedicated pin, 1 = sync-on-green).
- R4: With `force_i`=0, when both inputs are active or neither is, `use_sog_o` equals `prio_sog_i`.
- R5: With `force_i`=1, `use_sog_o` equals `prio_sog_i` whatever the activity state.
- R6: `hs_pol_high_o` becomes 1 when a measured high phase of `hsync_i` is shorter than the following low phase, and 0 when it is longer. It keeps its value on a tie and while the input is static.
- R7: `sync_o` equals the synchronized `sog_i` when `use_sog_o` is 1. Otherwise it equals the synchronized `hsync_i` when `hs_pol_high_o` is 1, and its inverse when `hs_pol_high_o` is 0. The synchronized value lags the pin by two clock edges.
- R8: After reset both activity bits are 0 and `hs_pol_high_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Dedicated horizontal sync pin |
| sog_i | input | 1 | Sliced sync-on-green signal |
| prio_sog_i | input | 1 | Priority bit, 1 prefers sync-on-green |
| force_i | input | 1 | Override: source always follows the priority bit |
| hs_active_o | output | 1 | Activity seen on the dedicated input |
| sog_active_o | output | 1 | Activity seen on sync-on-green |
| use_sog_o | output | 1 | Chosen source, 0 dedicated, 1 sync-on-green |
| hs_pol_high_o | output | 1 | Detected polarity of the dedicated input, 1 active-high |
| sync_o | output | 1 | Chosen sync, normalized |

## Verification
An edge on a pin shows up on its activity bit three clock edges later. Silence clears the bit ACT_WINDOW edges after the last edge was registered. Polarity settles within one period of the input. For these reasons, every configuration is held for 40 clocks before its status outputs are compared. `sync_o` is due one edge after the pin value has been captured, so the bench compares it with the pin value it recorded at the previous sample point. It samples 2 ns after each rising edge and drives the inputs on falling edges.

// File: rtl/hsync_source_select.sv
module hsync_source_select #(
  parameter int ACT_WINDOW = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_i,
  input  logic sog_i,
  input  logic prio_sog_i,
  input  logic force_i,
  output logic hs_active_o,
  output logic sog_active_o,
  output logic use_sog_o,
  output logic hs_pol_high_o,
  output logic sync_o
);

  localparam int CW = $clog2(ACT_WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(ACT_WINDOW - 1);

  logic [1:0]    hs_sy, sog_sy;
  logic          hs_d, sog_d;
  logic [CW-1:0] hs_cnt, sog_cnt, hi_len;

  wire hs_s     = hs_sy[1];
  wire sog_s    = sog_sy[1];
  wire hs_edge  = hs_s ^ hs_d;
  wire sog_edge = sog_s ^ sog_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_sy  <= '0;
      sog_sy <= '0;
      hs_d   <= 1'b0;
      sog_d  <= 1'b0;
    end else begin
      hs_sy  <= {hs_sy[0], hsync_i};
      sog_sy <= {sog_sy[0], sog_i};
      hs_d   <= hs_s;
      sog_d  <= sog_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_cnt      <= '0;
      hs_active_o <= 1'b0;
    end else if (hs_edge) begin
      hs_cnt      <= '0;
      hs_active_o <= 1'b1;
    end else if (hs_cnt == LAST) begin
      hs_active_o <= 1'b0;
    end else begin
      hs_cnt <= hs_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sog_cnt      <= '0;
      sog_active_o <= 1'b0;
    end else if (sog_edge) begin
      sog_cnt      <= '0;
      sog_active_o <= 1'b1;
    end else if (sog_cnt == LAST) begin
      sog_active_o <= 1'b0;
    end else begin
      sog_cnt <= sog_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_len        <= '0;
      hs_pol_high_o <= 1'b1;
    end else if (hs_edge && !hs_s) begin
      hi_len <= hs_cnt;
    end else if (hs_edge && hs_s) begin
      if (hi_len < hs_cnt)      hs_pol_high_o <= 1'b1;
      else if (hi_len > hs_cnt) hs_pol_high_o <= 1'b0;
    end

  assign use_sog_o = (!force_i && (hs_active_o ^ sog_active_o)) ? sog_active_o : prio_sog_i;
  assign sync_o    = use_sog_o ? sog_s : (hs_s ~^ hs_pol_high_o);

  AST_HS_EDGE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> hs_active_o);  // R1
  AST_HS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_edge && $past(!hs_edge) && !hs_active_o) |=> !hs_active_o || hs_edge || $past(hs_edge));  // R1
  AST_SOG_EDGE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sog_edge |=> sog_active_o);  // R2
  AST_ONLY_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && hs_active_o && !sog_active_o) |-> !use_sog_o);  // R3
  AST_ONLY_SOG: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && !hs_active_o && sog_active_o) |-> use_sog_o);  // R3
  AST_TIE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_active_o == sog_active_o) |-> (use_sog_o == prio_sog_i));  // R4
  AST_FORCE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |-> (use_sog_o == prio_sog_i));  // R5
  AST_POL_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_edge |=> $stable(hs_pol_high_o));  // R6
  AST_SOG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    use_sog_o |-> (sync_o == sog_sy[1]));  // R7

endmodule

// File: tb/test_hsync_source_select.sv
module test_hsync_source_select;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync_i = 1'b0, sog_i = 1'b0, prio_sog_i = 1'b0, force_i = 1'b0;
  logic hs_active_o, sog_active_o, use_sog_o, hs_pol_high_o, sync_o;

  int vectors = 0, miscompares = 0;
  int hs_hi = 0, hs_lo = 0, sog_hi = 0, sog_lo = 0;
  logic hs_lvl = 1'b0, sog_lvl = 1'b0;

  always #4 clk = ~clk;

  hsync_source_select #(.ACT_WINDOW(W)) i_hsync_source_select (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .sog_i(sog_i),
    .prio_sog_i(prio_sog_i), .force_i(force_i),
    .hs_active_o(hs_active_o), .sog_active_o(sog_active_o),
    .use_sog_o(use_sog_o), .hs_pol_high_o(hs_pol_high_o), .sync_o(sync_o));

  initial begin : hs_drv
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      if (hs_hi == 0) begin hsync_i = hs_lvl; c = 0; end
      else begin
        c++;
        if (hsync_i && c >= hs_hi) begin hsync_i = 1'b0; c = 0; end
        else if (!hsync_i && c >= hs_lo) begin hsync_i = 1'b1; c = 0; end
      end
    end
  end

  initial begin : sog_drv
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      if (sog_hi == 0) begin sog_i = sog_lvl; c = 0; end
      else begin
        c++;
        if (sog_i && c >= sog_hi) begin sog_i = 1'b0; c = 0; end
        else if (!sog_i && c >= sog_lo) begin sog_i = 1'b1; c = 0; end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic exp_pol, exp_hs, exp_sog, exp_use, hs_prev, sog_prev;
    exp_pol = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R8 hs_active reset", hs_active_o, 1'b0);
    check("R8 sog_active reset", sog_active_o, 1'b0);
    check("R8 polarity reset", hs_pol_high_o, 1'b1);
    @(negedge clk) rst_n = 1'b1;

    for (int hm = 0; hm < 4; hm++)
      for (int sm = 0; sm < 3; sm++)
        for (int pf = 0; pf < 4; pf++) begin
          @(negedge clk);
          case (hm)
            0: begin hs_hi = 0; hs_lvl = 1'b0; end
            1: begin hs_hi = 0; hs_lvl = 1'b1; end
            2: begin hs_hi = 2; hs_lo = 6; end
            default: begin hs_hi = 6; hs_lo = 2; end
          endcase
          case (sm)
            0: begin sog_hi = 0; sog_lvl = 1'b0; end
            1: begin sog_hi = 0; sog_lvl = 1'b1; end
            default: begin sog_hi = 3; sog_lo = 3; end
          endcase
          prio_sog_i = pf[0];
          force_i    = pf[1];
          if (hm == 2) exp_pol = 1'b1;
          if (hm == 3) exp_pol = 1'b0;
          exp_hs  = (hm >= 2);
          exp_sog = (sm == 2);
          exp_use = (!pf[1] && (exp_hs != exp_sog)) ? exp_sog : pf[0];
          repeat (40) @(posedge clk);
          #2;
          check("R1 hs activity", hs_active_o, exp_hs);
          check("R2 sog activity", sog_active_o, exp_sog);
          if (pf[1]) check("R5 forced source", use_sog_o, exp_use);
          else if (exp_hs != exp_sog) check("R3 single source", use_sog_o, exp_use);
          else check("R4 tie uses priority", use_sog_o, exp_use);
          check("R6 polarity", hs_pol_high_o, exp_pol);
          hs_prev  = hsync_i;
          sog_prev = sog_i;
          for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            #2;
            check("R7 sync output", sync_o, exp_use ? sog_prev : (hs_prev ~^ exp_pol));
            hs_prev  = hsync_i;
            sog_prev = sog_i;
          end
        end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule